// File: doc/BRIEF.md
# Isochronous Interval Token Monitor

This block follows the frame schedule on which one isochronous IN pipe of a USB function controller expects an IN token. Each frame begins with a frame-start strobe. The strobe comes either from a received SOF packet or from the interpolated timing that fills in for a damaged one. The block keeps a frame counter driven by these strobes. It raises a window output during each frame in which a token is expected.

When flushing is enabled and the FIFO still holds data, an expected frame may end without a clean IN token. This covers a token that never arrives and a token that arrives with a bus error. In that case the block emits a single-cycle FIFO-clear pulse at the next frame start.

Counting for a nonzero interval begins only after the first good data packet that follows the pipe entering its BUF response state. Several events return the block to its idle, not-started condition: hardware reset, a software auto-clear request, a detected bus reset, and the pipe being in NAK.

Top module: `iso_tok_sched`

## Requirements
- R1: After `rst_i` (synchronous, active high) is released, `tok_win_o` and `fifo_clr_o` are both 0, and the captured interval setting is 0.
- R2: With `ivl_sel_i` = 0 and `pipe_buf_i` = 1, every frame start sets `tok_win_o` to 1 for the frame it opens, with no data packet needed.
- R3: With a nonzero setting n, `tok_win_o` stays 0 until a good data packet (`dat_ok_i`) arrives. Counting frame starts from that packet's frame, `tok_win_o` is 1 exactly in frames 2^n, 2·2^n, and so on, with n up to 7.
- R4: The setting is captured when counting starts. Later changes to `ivl_sel_i` do not move the schedule until the next restart.
- R5: If an expected frame ends with no good IN token while `flush_en_i` = 1 and `fifo_pend_i` = 1, `fifo_clr_o` is 1 for exactly the one cycle after the clock edge that samples the next frame start.
- R6: An IN token flagged with `tok_err_i` = 1 counts as not received, whether or not `tok_ok_i` is also high, so it still leads to the clear of R5.
- R7: A good IN token (`tok_ok_i` = 1, `tok_err_i` = 0) in an expected frame cancels the clear for that frame.
- R8: No clear is produced when `flush_en_i` = 0 or `fifo_pend_i` = 0 at the frame start that ends the expected frame.
- R9: A frame that was not an expected frame never produces a clear, whatever tokens it saw.
- R10: While `pipe_buf_i` = 0 (NAK), the counter is idle: window 0, no clears. After returning to 1 (BUF), a new good data packet is needed before a nonzero-interval schedule resumes.
- R11: `aclr_i` or `bus_rst_i` returns the block to idle, as in R10. Window and clear are 0 from the next cycle, and a pending clear is dropped.
- R12: `sof_i` (real SOF) and `sof_fill_i` (interpolated SOF) act alike. When both are high in the same cycle they form one frame start and produce at most one clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Frame start from a received SOF packet |
| sof_fill_i | input | 1 | Frame start from interpolated SOF timing |
| tok_ok_i | input | 1 | IN token received for this pipe |
| tok_err_i | input | 1 | IN token received with a bus error |
| dat_ok_i | input | 1 | Data packet received without error |
| pipe_buf_i | input | 1 | Pipe response state: 1 = BUF, 0 = NAK |
| ivl_sel_i | input | IVL_W | Interval setting n, interval of 2^n frames |
| flush_en_i | input | 1 | Enables the FIFO clear on a missed token |
| fifo_pend_i | input | 1 | FIFO holds data awaiting transmission |
| aclr_i | input | 1 | Software auto-clear request for the pipe |
| bus_rst_i | input | 1 | USB bus reset detected |
| tok_win_o | output | 1 | Current frame is an expected-token frame |
| fifo_clr_o | output | 1 | One-cycle FIFO clear pulse |

## Verification
The schedule is swept over settings 0, 1, 2, 3 and 7 with all four combinations of flush enable and pending data. In each frame of the sweep, the IN-token activity rotates among a good token, an error token and silence. This separates the window arithmetic from the clear qualification, because a clear is expected only for an expected frame that lacked a good token with both qualifiers set.

The frame-start source also rotates between real, interpolated and both together. This shows that the clear does not depend on which strobe fired.

Separate runs cover four cases:
- The setting changes after counting has started, which shows it was captured at start.
- The pipe drops to NAK with a clear pending, and must then wait for a fresh data packet.
- A bus reset arrives in the middle of the schedule.
- Both strobes fire together, which must yield a single clear.

// File: rtl/iso_tok_pkg.sv
package iso_tok_pkg;

  localparam int IVL_W_DEF = 3;

  typedef enum logic {
    RSP_NAK = 1'b0,
    RSP_BUF = 1'b1
  } rsp_e;

endpackage

// File: rtl/iso_tok_evt.sv
module iso_tok_evt
  import iso_tok_pkg::*;
(
  input  logic rst_i,
  input  logic aclr_i,
  input  logic bus_rst_i,
  input  logic pipe_buf_i,
  input  logic sof_i,
  input  logic sof_fill_i,
  output logic restart_o,
  output logic fs_o
);

  rsp_e rsp;

  always_comb begin
    rsp       = rsp_e'(pipe_buf_i);
    // any of these puts the schedule back to its not-started state
    restart_o = rst_i | aclr_i | bus_rst_i | (rsp == RSP_NAK);
    // a real and an interpolated strobe merge into one frame start
    fs_o      = sof_i | sof_fill_i;
  end

endmodule

// File: rtl/iso_tok_frame_ctr.sv
module iso_tok_frame_ctr #(
  parameter int IVL_W = 3,
  localparam int CNT_W = (1 << IVL_W) - 1
) (
  input  logic             clk_i,
  input  logic             restart_i,
  input  logic             fs_i,
  input  logic             dat_ok_i,
  input  logic [IVL_W-1:0] ivl_sel_i,
  output logic             win_o
);

  logic             started_q;
  logic [IVL_W-1:0] ivl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             win_q;
  logic [IVL_W-1:0] ivl_eff;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_inc;
  logic             active;
  logic             start_now;

  always_comb begin
    ivl_eff   = started_q ? ivl_q : ivl_sel_i;
    active    = started_q | (ivl_sel_i == '0);
    start_now = ~started_q & dat_ok_i & (ivl_sel_i != '0);
  end

  // low ivl_eff bits of the counter take part in the wrap
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
    assign mask[gi] = (32'(ivl_eff) > gi);
  end

  assign cnt_inc = (cnt_q + 1'b1) & mask;

  always_ff @(posedge clk_i) begin
    if (restart_i) begin
      started_q <= 1'b0;
      ivl_q     <= '0;
      cnt_q     <= '0;
      win_q     <= 1'b0;
    end else if (start_now) begin
      started_q <= 1'b1;
      ivl_q     <= ivl_sel_i;
      cnt_q     <= '0;
      win_q     <= 1'b0;
    end else if (fs_i) begin
      if (active) begin
        cnt_q <= cnt_inc;
        win_q <= (cnt_inc == '0);
      end else begin
        cnt_q <= '0;
        win_q <= 1'b0;
      end
    end
  end

  assign win_o = win_q;

  // R3
  win_rise_chk: assert property (@(posedge clk_i) disable iff (restart_i)
    $rose(win_q) |-> $past(fs_i));

  // R4
  ivl_hold_chk: assert property (@(posedge clk_i) disable iff (restart_i)
    (started_q && $past(started_q)) |-> $stable(ivl_q));

endmodule

// File: rtl/iso_tok_miss_trk.sv
module iso_tok_miss_trk (
  input  logic clk_i,
  input  logic restart_i,
  input  logic fs_i,
  input  logic win_i,
  input  logic tok_ok_i,
  input  logic tok_err_i,
  input  logic flush_en_i,
  input  logic fifo_pend_i,
  output logic clr_o
);

  logic seen_q;
  logic clr_q;
  logic good_tok;

  assign good_tok = tok_ok_i & ~tok_err_i;

  always_ff @(posedge clk_i) begin
    if (restart_i) begin
      seen_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      // decision for the frame that this frame start closes
      clr_q <= fs_i & win_i & ~seen_q & flush_en_i & fifo_pend_i;
      if (fs_i)
        seen_q <= 1'b0;
      else if (good_tok)
        seen_q <= 1'b1;
    end
  end

  assign clr_o = clr_q;

  // R5
  clr_at_fs_chk: assert property (@(posedge clk_i) disable iff (restart_i)
    clr_q |-> $past(fs_i));

  // R8
  clr_cfg_chk: assert property (@(posedge clk_i) disable iff (restart_i)
    clr_q |-> $past(flush_en_i && fifo_pend_i));

  // R9
  clr_win_chk: assert property (@(posedge clk_i) disable iff (restart_i)
    clr_q |-> $past(win_i));

endmodule

// File: rtl/iso_tok_sched.sv
module iso_tok_sched
  import iso_tok_pkg::*;
#(
  parameter int IVL_W = IVL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sof_i,
  input  logic             sof_fill_i,
  input  logic             tok_ok_i,
  input  logic             tok_err_i,
  input  logic             dat_ok_i,
  input  logic             pipe_buf_i,
  input  logic [IVL_W-1:0] ivl_sel_i,
  input  logic             flush_en_i,
  input  logic             fifo_pend_i,
  input  logic             aclr_i,
  input  logic             bus_rst_i,
  output logic             tok_win_o,
  output logic             fifo_clr_o
);

  logic restart;
  logic fs;
  logic win;
  logic clr;

  iso_tok_evt u_evt (
    .rst_i      (rst_i),
    .aclr_i     (aclr_i),
    .bus_rst_i  (bus_rst_i),
    .pipe_buf_i (pipe_buf_i),
    .sof_i      (sof_i),
    .sof_fill_i (sof_fill_i),
    .restart_o  (restart),
    .fs_o       (fs)
  );

  iso_tok_frame_ctr #(.IVL_W(IVL_W)) u_ctr (
    .clk_i     (clk_i),
    .restart_i (restart),
    .fs_i      (fs),
    .dat_ok_i  (dat_ok_i),
    .ivl_sel_i (ivl_sel_i),
    .win_o     (win)
  );

  iso_tok_miss_trk u_miss (
    .clk_i       (clk_i),
    .restart_i   (restart),
    .fs_i        (fs),
    .win_i       (win),
    .tok_ok_i    (tok_ok_i),
    .tok_err_i   (tok_err_i),
    .flush_en_i  (flush_en_i),
    .fifo_pend_i (fifo_pend_i),
    .clr_o       (clr)
  );

  assign tok_win_o  = win;
  assign fifo_clr_o = clr;

  // R10
  nak_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !pipe_buf_i |=> (!tok_win_o && !fifo_clr_o));

  // R11
  restart_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (aclr_i || bus_rst_i) |=> (!tok_win_o && !fifo_clr_o));

  // R12
  clr_src_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fifo_clr_o |-> $past(sof_i || sof_fill_i));

endmodule

// File: tb/iso_tok_sched_tb.sv
module iso_tok_sched_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof = 1'b0, sof_fill = 1'b0;
  logic       tok_ok = 1'b0, tok_err = 1'b0, dat_ok = 1'b0;
  logic       pipe_buf = 1'b1;
  logic [2:0] ivl_sel = 3'd0;
  logic       flush_en = 1'b0, fifo_pend = 1'b0;
  logic       aclr = 1'b0, bus_rst = 1'b0;
  logic       tok_win, fifo_clr;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  iso_tok_sched #(.IVL_W(3)) dut_i (
    .clk_i(clk), .rst_i(rst), .sof_i(sof), .sof_fill_i(sof_fill),
    .tok_ok_i(tok_ok), .tok_err_i(tok_err), .dat_ok_i(dat_ok),
    .pipe_buf_i(pipe_buf), .ivl_sel_i(ivl_sel), .flush_en_i(flush_en),
    .fifo_pend_i(fifo_pend), .aclr_i(aclr), .bus_rst_i(bus_rst),
    .tok_win_o(tok_win), .fifo_clr_o(fifo_clr)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic fs_pulse(input logic r, input logic f);
    sof = r; sof_fill = f;
    tick();
    sof = 1'b0; sof_fill = 1'b0;
  endtask

  // a: 0 good token, 1 error token, 2 silence
  task automatic tok_frame(input int a);
    tok_ok  = (a == 0);
    tok_err = (a == 1);
    tick();
    tok_ok = 1'b0; tok_err = 1'b0;
    tick();
  endtask

  task automatic data_pkt();
    dat_ok = 1'b1;
    tick();
    dat_ok = 1'b0;
    tick();
  endtask

  task automatic restart_aclr();
    aclr = 1'b1;
    tick();
    aclr = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R1 watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int nv[5] = '{0, 1, 2, 3, 7};
    logic prev_win, prev_good, exp_win, exp_clr;
    int prev_act;
    string rq;

    // R1 reset state
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1", "win after reset", tok_win, 1'b0);
    chk("R1", "clr after reset", fifo_clr, 1'b0);

    // interval sweep over settings and qualifiers
    for (int ni = 0; ni < 5; ni++) begin
      for (int c = 0; c < 4; c++) begin
        int n;
        logic fe, pd;
        n = nv[ni];
        fe = c[1]; pd = c[0];
        flush_en = fe; fifo_pend = pd; ivl_sel = 3'(n);
        restart_aclr();
        chk("R11", "win after aclr", tok_win, 1'b0);
        chk("R11", "clr after aclr", fifo_clr, 1'b0);
        if (n != 0) begin
          fs_pulse(1'b1, 1'b0);
          chk("R3", "win before data", tok_win, 1'b0);
          tick();
        end
        data_pkt();
        prev_win = 1'b0; prev_good = 1'b0; prev_act = 2;
        for (int k = 1; k <= 2 * (1 << n) + 1; k++) begin
          int a;
          fs_pulse(k % 3 != 2, k % 3 != 0);
          exp_clr = prev_win && !prev_good && fe && pd;
          exp_win = ((k % (1 << n)) == 0);
          if (!prev_win) rq = "R9";
          else if (!(fe && pd)) rq = "R8";
          else if (prev_good) rq = "R7";
          else if (prev_act == 1) rq = "R6";
          else rq = "R5";
          chk(rq, "clr at frame start", fifo_clr, exp_clr);
          chk((n == 0) ? "R2" : "R3", "window", tok_win, exp_win);
          tick();
          chk("R5", "clr one cycle", fifo_clr, 1'b0);
          a = k % 3;
          tok_frame(a);
          prev_win = exp_win; prev_good = (a == 0); prev_act = a;
        end
      end
    end

    // R4 setting captured at start
    flush_en = 1'b1; fifo_pend = 1'b1; ivl_sel = 3'd2;
    restart_aclr();
    data_pkt();
    ivl_sel = 3'd1;
    prev_win = 1'b0;
    for (int k = 1; k <= 9; k++) begin
      fs_pulse(1'b1, 1'b0);
      chk("R4", "clr keeps captured interval", fifo_clr, prev_win);
      exp_win = ((k % 4) == 0);
      chk("R4", "window keeps captured interval", tok_win, exp_win);
      prev_win = exp_win;
      tick(); tick();
    end

    // R10 NAK drops pending clear and needs new data
    ivl_sel = 3'd1;
    restart_aclr();
    data_pkt();
    fs_pulse(1'b1, 1'b0); tick();
    fs_pulse(1'b1, 1'b0);
    chk("R10", "window before NAK", tok_win, 1'b1);
    tick();
    pipe_buf = 1'b0;
    tick();
    chk("R10", "window in NAK", tok_win, 1'b0);
    pipe_buf = 1'b1;
    tick();
    fs_pulse(1'b1, 1'b0);
    chk("R10", "no clear after NAK", fifo_clr, 1'b0);
    for (int k = 0; k < 3; k++) begin
      tick();
      fs_pulse(1'b0, 1'b1);
      chk("R10", "idle until data", tok_win, 1'b0);
    end
    tick();
    data_pkt();
    fs_pulse(1'b1, 1'b0);
    chk("R10", "frame 1 after data", tok_win, 1'b0);
    tick();
    fs_pulse(1'b1, 1'b0);
    chk("R10", "frame 2 after data", tok_win, 1'b1);
    tick();

    // R11 bus reset mid schedule
    bus_rst = 1'b1;
    tick();
    bus_rst = 1'b0;
    chk("R11", "window after bus reset", tok_win, 1'b0);
    fs_pulse(1'b1, 1'b0);
    chk("R11", "pending clear dropped", fifo_clr, 1'b0);
    chk("R11", "window stays idle", tok_win, 1'b0);
    tick();

    // R12 both strobes together give one clear
    ivl_sel = 3'd0;
    restart_aclr();
    fs_pulse(1'b1, 1'b0);
    chk("R12", "window opened", tok_win, 1'b1);
    tick();
    fs_pulse(1'b1, 1'b1);
    chk("R12", "clear on merged strobes", fifo_clr, 1'b1);
    tick();
    chk("R12", "single clear pulse", fifo_clr, 1'b0);
    fs_pulse(1'b0, 1'b1);
    chk("R12", "clear on interpolated strobe", fifo_clr, 1'b1);
    tick();

    finish_run();
  end

endmodule